// File: doc/BRIEF.md
# Receive Checksum Offload Stage

This stage sits in the receive byte stream of an Ethernet MAC. Every frame passes through it unchanged. While a frame passes, the stage parses the frame header and accumulates a 16-bit ones'-complement sum over the layer-3 packet. When the frame's last byte has been forwarded, the stage emits two more bytes that carry the sum. It then reports the frame length, counting those two extra bytes, so that the receive status word can record it.

The layer-3 packet is located by walking the header. The walk skips up to two 802.1Q tags and reads the type/length word. In one mode it also steps over an LLC/SNAP header. The last four bytes of the frame are the FCS and are never summed. A four-byte delay on the summing path holds each byte until it is known not to be FCS. When the stage is disabled, frames go through untouched. The enable and mode inputs take effect only at frame boundaries.

Top module: `rxcsum_engine`

## Requirements
- R1: For an untagged frame whose 16-bit word at byte offset 12 is 0x0600 or more, the sum covers bytes from offset 14 up to, but not including, the final 4 (FCS) bytes.
- R2: A word equal to 0x8100 where the type is expected is a VLAN tag. The 4-byte tag is skipped and the type is read 4 bytes later. At most two tags are skipped this way.
- R3: A third 0x8100 word is taken as the type itself, and the sum starts on the byte directly after it.
- R4: When enabled, the two checksum bytes follow the frame's last byte, high byte first. out_last is raised only on the second of them, and in_ready stays low while they are emitted.
- R5: The summed bytes are paired big-endian into 16-bit words. A trailing odd byte is padded with a zero low byte. Carries are folded back into the sum, and the result is sent without inversion.
- R6: One cycle after a frame's last byte is accepted, len_valid pulses for one cycle. At the same time len_bytes shows the received byte count, plus 2 when the frame was enabled.
- R7: With cfg_en low at a frame's first byte, the frame is forwarded byte for byte. out_last falls on its own last byte, nothing is appended, and the reported length equals the received length.
- R8: In mode 0 (cfg_mode low), a frame whose type/length word is below 0x0600 gets an appended checksum of 0x0000.
- R9: In mode 1, a word below 0x0600 is followed by an 8-byte LLC/SNAP header (DSAP, SSAP, control, 3-byte OUI, 2-byte protocol ID), and the sum starts after the protocol ID. Frames with a word of 0x0600 or more are summed as in R1.
- R10: cfg_en and cfg_mode are sampled when a frame's first byte is accepted. Changes later in the frame do not affect that frame.
- R11: A frame whose header (including any SNAP header) ends inside the FCS bytes or past the frame end gets an appended checksum of 0x0000.
- R12: After reset, out_valid and len_valid are low, and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Checksum insertion enable, sampled per frame |
| cfg_mode | input | 1 | 0: type-coded frames only; 1: also LLC/SNAP |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the frame's last (FCS) byte |
| in_ready | output | 1 | Stage accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |
| out_ready | input | 1 | Downstream accepts the output byte |
| len_valid | output | 1 | Frame length strobe |
| len_bytes | output | LEN_W | Reported frame length in bytes |

## Verification
The hardest cases to reach from the ports are frames whose header boundary sits next to the FCS. A tag or SNAP header that completes only inside the last four bytes must give a zero sum. One that completes just before them must give a correct, possibly odd-length sum. The bench builds frames of chosen lengths around those boundaries, including a 16-byte frame whose type word ends inside the FCS. It repeats the tag and SNAP layouts under random downstream backpressure, so that the appended bytes stall while the next frame is already waiting. It also changes cfg_en and cfg_mode part-way through a frame to show that they are latched at the first byte.

// File: rtl/rxcsum_pkg.sv
package rxcsum_pkg;

   typedef enum logic [1:0] {
      PH_TYPE,
      PH_SKIP,
      PH_SUM,
      PH_NONE
   } parse_ph_t;

   typedef enum logic [1:0] {
      OS_PASS,
      OS_APP_HI,
      OS_APP_LO
   } out_st_t;

   localparam int unsigned TYPE_OFS  = 12;
   localparam int unsigned TAG_BYTES = 4;

   function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

endpackage

// File: rtl/rxcsum_delay.sv
module rxcsum_delay #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("rxcsum_delay: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] stage_q;
      always_ff @(posedge clk) begin
         if (!rst_n)     stage_q <= '0;
         else if (shift) stage_q <= din;
      end
      assign dout = stage_q;
   end else begin : g_chain
      logic [DEPTH*W-1:0] pipe_q;
      always_ff @(posedge clk) begin
         if (!rst_n)     pipe_q <= '0;
         else if (shift) pipe_q <= {pipe_q[(DEPTH-1)*W-1:0], din};
      end
      assign dout = pipe_q[DEPTH*W-1 -: W];
   end

endmodule

// File: rtl/rxcsum_parser.sv
module rxcsum_parser
   import rxcsum_pkg::*;
#(
   parameter int unsigned LEN_W      = 14,
   parameter int unsigned MAX_TAGS   = 2,
   parameter int unsigned SNAP_BYTES = 8,
   parameter logic [15:0] TPID       = 16'h8100,
   parameter logic [15:0] TYPE_MIN   = 16'h0600
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             mode,
   input  logic [LEN_W-1:0] idx,
   input  logic [7:0]       d,
   output logic             sum_step
);

   localparam int unsigned TAG_W  = $clog2(MAX_TAGS + 1);
   localparam int unsigned SKIP_W = $clog2(SNAP_BYTES + 1);

   if (SNAP_BYTES < 1) begin : g_bad_snap
      $error("rxcsum_parser: SNAP_BYTES must be at least 1");
   end

   parse_ph_t          ph_q;
   logic [LEN_W-1:0]   tpos_q;
   logic [TAG_W-1:0]   tags_q;
   logic [SKIP_W-1:0]  skip_q;
   logic [7:0]         thi_q;
   logic [15:0]        word;

   assign word     = {thi_q, d};
   assign sum_step = step && (ph_q == PH_SUM);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ph_q   <= PH_TYPE;
         tpos_q <= LEN_W'(TYPE_OFS);
         tags_q <= '0;
         skip_q <= '0;
         thi_q  <= '0;
      end else if (step) begin
         case (ph_q)
            PH_TYPE: begin
               if (idx == tpos_q) begin
                  thi_q <= d;
               end else if (idx == tpos_q + LEN_W'(1)) begin
                  if (word == TPID && tags_q < TAG_W'(MAX_TAGS)) begin
                     tags_q <= tags_q + TAG_W'(1);
                     tpos_q <= tpos_q + LEN_W'(TAG_BYTES);
                  end else if (word >= TYPE_MIN) begin
                     ph_q <= PH_SUM;
                  end else if (mode) begin
                     ph_q   <= PH_SKIP;
                     skip_q <= SKIP_W'(SNAP_BYTES);
                  end else begin
                     ph_q <= PH_NONE;
                  end
               end
            end
            PH_SKIP: begin
               skip_q <= skip_q - SKIP_W'(1);
               if (skip_q == SKIP_W'(1)) ph_q <= PH_SUM;
            end
            default: ;
         endcase
      end
   end

   // R2
   tag_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tags_q <= TAG_W'(MAX_TAGS));

   // R1
   sum_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SUM && !clr) |=> (ph_q == PH_SUM));

endmodule

// File: rtl/rxcsum_accum.sv
module rxcsum_accum
   import rxcsum_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        step,
   input  logic [7:0]  d,
   output logic [15:0] csum
);

   logic [15:0] sum_q;
   logic [7:0]  whi_q;
   logic        half_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sum_q  <= '0;
         whi_q  <= '0;
         half_q <= 1'b0;
      end else if (step) begin
         if (!half_q) begin
            whi_q  <= d;
            half_q <= 1'b1;
         end else begin
            sum_q  <= oc_add(sum_q, {whi_q, d});
            half_q <= 1'b0;
         end
      end
   end

   always_comb begin
      csum = oc_add(sum_q, half_q ? {whi_q, 8'h00} : 16'h0000);
   end

   // R11
   cleared_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (csum == 16'h0000));

endmodule

// File: rtl/rxcsum_engine.sv
module rxcsum_engine
   import rxcsum_pkg::*;
#(
   parameter int unsigned LEN_W      = 14,
   parameter int unsigned FCS_BYTES  = 4,
   parameter int unsigned MAX_TAGS   = 2,
   parameter int unsigned SNAP_BYTES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_mode,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   output logic             in_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_last,
   input  logic             out_ready,
   output logic             len_valid,
   output logic [LEN_W-1:0] len_bytes
);

   if (LEN_W < 8) begin : g_bad_len
      $error("rxcsum_engine: LEN_W must be at least 8");
   end
   if (FCS_BYTES < 1) begin : g_bad_fcs
      $error("rxcsum_engine: FCS_BYTES must be at least 1");
   end

   out_st_t          st_q;
   logic [LEN_W-1:0] cnt_q;
   logic             cur_en_q;
   logic             cur_mode_q;
   logic             len_valid_q;
   logic [LEN_W-1:0] len_q;

   logic             first;
   logic             en_eff;
   logic             acc;
   logic             proc;
   logic             clr;
   logic             sum_step;
   logic [LEN_W-1:0] idx;
   logic [7:0]       dly_byte;
   logic [15:0]      csum;

   assign first  = (cnt_q == '0);
   assign en_eff = first ? cfg_en : cur_en_q;
   assign acc    = in_valid && in_ready;
   assign proc   = acc && en_eff && (cnt_q >= LEN_W'(FCS_BYTES));
   assign idx    = cnt_q - LEN_W'(FCS_BYTES);
   assign clr    = (acc && in_last && !en_eff) || (st_q == OS_APP_LO && out_ready);

   assign in_ready = (st_q == OS_PASS) && out_ready;

   always_comb begin
      case (st_q)
         OS_APP_HI: begin
            out_valid = 1'b1;
            out_data  = csum[15:8];
            out_last  = 1'b0;
         end
         OS_APP_LO: begin
            out_valid = 1'b1;
            out_data  = csum[7:0];
            out_last  = 1'b1;
         end
         default: begin
            out_valid = in_valid;
            out_data  = in_data;
            out_last  = in_last && !en_eff;
         end
      endcase
   end

   assign len_valid = len_valid_q;
   assign len_bytes = len_q;

   rxcsum_delay #(
      .DEPTH (FCS_BYTES),
      .W     (8)
   ) delay_i (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (acc),
      .din   (in_data),
      .dout  (dly_byte)
   );

   rxcsum_parser #(
      .LEN_W      (LEN_W),
      .MAX_TAGS   (MAX_TAGS),
      .SNAP_BYTES (SNAP_BYTES)
   ) parser_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .step     (proc),
      .mode     (cur_mode_q),
      .idx      (idx),
      .d        (dly_byte),
      .sum_step (sum_step)
   );

   rxcsum_accum accum_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (sum_step),
      .d     (dly_byte),
      .csum  (csum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= OS_PASS;
         cnt_q       <= '0;
         cur_en_q    <= 1'b0;
         cur_mode_q  <= 1'b0;
         len_valid_q <= 1'b0;
         len_q       <= '0;
      end else begin
         len_valid_q <= 1'b0;
         case (st_q)
            OS_PASS: begin
               if (acc) begin
                  if (first) begin
                     cur_en_q   <= cfg_en;
                     cur_mode_q <= cfg_mode;
                  end
                  if (in_last) begin
                     len_valid_q <= 1'b1;
                     len_q       <= cnt_q + LEN_W'(1) + (en_eff ? LEN_W'(2) : LEN_W'(0));
                     cnt_q       <= '0;
                     if (en_eff) st_q <= OS_APP_HI;
                  end else begin
                     cnt_q <= cnt_q + LEN_W'(1);
                  end
               end
            end
            OS_APP_HI: if (out_ready) st_q <= OS_APP_LO;
            OS_APP_LO: if (out_ready) st_q <= OS_PASS;
            default:   st_q <= OS_PASS;
         endcase
      end
   end

   // R4
   append_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_last && en_eff) |=> (out_valid && !in_ready && !out_last));

   // R4
   append_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OS_APP_HI && out_ready) |=> (out_valid && out_last && !in_ready));

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |=> ($stable(cur_en_q) && $stable(cur_mode_q)));

endmodule

// File: tb/rxcsum_engine_tb_top.sv
module rxcsum_engine_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 14;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_en = 1'b0;
   logic             cfg_mode = 1'b0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_data = 8'h00;
   logic             in_last = 1'b0;
   logic             in_ready;
   logic             out_valid;
   logic [7:0]       out_data;
   logic             out_last;
   logic             out_ready = 1'b1;
   logic             len_valid;
   logic [LEN_W-1:0] len_bytes;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  bp_on    = 1'b0;
   bit  finished = 1'b0;

   logic [7:0] frm[$];
   logic [7:0] exp_data[$];
   bit         exp_last[$];
   bit         exp_app[$];
   string      exp_tag[$];
   int         exp_len[$];
   string      len_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rxcsum_engine #(.LEN_W(LEN_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_en    (cfg_en),
      .cfg_mode  (cfg_mode),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_last   (in_last),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_last  (out_last),
      .out_ready (out_ready),
      .len_valid (len_valid),
      .len_bytes (len_bytes)
   );

   task automatic check(input string tag, input bit ok, input int act, input int expv, input string what);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
      end
   endtask

   function automatic logic [15:0] model_sum(input bit mode);
      int n, lim, pos, tags, start;
      logic [15:0] v, w, a;
      logic [16:0] s;
      n = frm.size(); lim = n - 4; pos = 12; tags = 0; start = -1; a = 16'h0;
      while (start < 0) begin
         if (pos + 1 >= lim) return 16'h0000;
         v = {frm[pos], frm[pos+1]};
         if (v == 16'h8100 && tags < 2) begin
            tags++; pos += 4;
         end else if (v >= 16'h0600) begin
            start = pos + 2;
         end else if (mode) begin
            start = pos + 10;
         end else begin
            return 16'h0000;
         end
      end
      for (int k = start; k < lim; k += 2) begin
         w = {frm[k], (k + 1 < lim) ? frm[k+1] : 8'h00};
         s = {1'b0, a} + {1'b0, w};
         a = s[15:0] + {15'd0, s[16]};
      end
      return a;
   endfunction

   task automatic put16(input logic [15:0] v);
      frm.push_back(v[15:8]);
      frm.push_back(v[7:0]);
   endtask

   task automatic put_rand(input int n);
      for (int i = 0; i < n; i++) frm.push_back(8'($urandom));
   endtask

   task automatic put_fill(input int n, input logic [7:0] b);
      for (int i = 0; i < n; i++) frm.push_back(b);
   endtask

   task automatic send_frame(input string tag, input bit en, input bit mode, input int flip_at);
      int n;
      logic [15:0] cs;
      n  = frm.size();
      cs = model_sum(mode);
      for (int i = 0; i < n; i++) begin
         exp_data.push_back(frm[i]);
         exp_last.push_back(i == n - 1 && !en);
         exp_app.push_back(1'b0);
         exp_tag.push_back(tag);
      end
      if (en) begin
         exp_data.push_back(cs[15:8]); exp_last.push_back(1'b0);
         exp_app.push_back(1'b1);      exp_tag.push_back(tag);
         exp_data.push_back(cs[7:0]);  exp_last.push_back(1'b1);
         exp_app.push_back(1'b1);      exp_tag.push_back(tag);
      end
      exp_len.push_back(n + (en ? 2 : 0));
      len_tag.push_back(tag);
      cfg_en   = en;
      cfg_mode = mode;
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1;
         in_data  = frm[i];
         in_last  = (i == n - 1);
         if (i == flip_at) begin
            cfg_en   = !en;
            cfg_mode = !mode;
         end
         forever begin
            @(negedge clk);
            if (in_ready) break;
         end
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      frm.delete();
   endtask

   always @(posedge clk) begin
      #1;
      out_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid && out_ready) begin
            if (exp_data.size() == 0) begin
               check("R7", 1'b0, out_data, 0, "unexpected output byte");
            end else begin
               string t;
               logic [7:0] ed;
               bit el, ea;
               t  = exp_tag.pop_front();
               ed = exp_data.pop_front();
               el = exp_last.pop_front();
               ea = exp_app.pop_front();
               check(t, out_data == ed, out_data, ed, "out_data");
               check(t, out_last == el, out_last, el, "out_last");
               // R4: input held off while appended bytes go out
               if (ea) check("R4", !in_ready, in_ready, 0, "in_ready during append");
            end
         end
         if (len_valid) begin
            if (exp_len.size() == 0) begin
               check("R6", 1'b0, len_bytes, 0, "unexpected len_valid");
            end else begin
               string t;
               int el;
               t  = len_tag.pop_front();
               el = exp_len.pop_front();
               check({t, "/R6"}, len_bytes == LEN_W'(el), len_bytes, el, "len_bytes");
            end
         end
      end
   end

   task automatic finish_run();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      @(negedge clk);
      // R12: reset state
      check("R12", out_valid == 1'b0, out_valid, 0, "out_valid in reset");
      check("R12", len_valid == 1'b0, len_valid, 0, "len_valid in reset");
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check("R12", out_valid == 1'b0, out_valid, 0, "out_valid after reset");
      check("R12", in_ready == out_ready, in_ready, out_ready, "in_ready after reset");
      @(posedge clk);
      #1;

      // R1: untagged Ethernet II
      put_rand(12); put16(16'h0800); put_rand(20); put_rand(4);
      send_frame("R1", 1, 0, -1);
      // R2 and R5: one tag, odd payload
      put_rand(12); put16(16'h8100); put16(16'h0123); put16(16'h86DD); put_rand(17); put_rand(4);
      send_frame("R2", 1, 0, -1);
      // R2: two tags
      put_rand(12); put16(16'h8100); put16(16'h0005); put16(16'h8100); put16(16'h0006);
      put16(16'h0800); put_rand(30); put_rand(4);
      send_frame("R2", 1, 0, -1);
      // R3: third tag becomes the type
      put_rand(12); put16(16'h8100); put16(16'h0001); put16(16'h8100); put16(16'h0002);
      put16(16'h8100); put16(16'h0003); put16(16'h0800); put_rand(10); put_rand(4);
      send_frame("R3", 1, 0, -1);
      // R9: SNAP in mode 1
      put_rand(12); put16(16'h0020); put16(16'hAAAA); frm.push_back(8'h03);
      put_fill(3, 8'h00); put16(16'h0800); put_rand(21); put_rand(4);
      send_frame("R9", 1, 1, -1);
      // R8: same layout in mode 0 gives zero
      put_rand(12); put16(16'h0020); put16(16'hAAAA); frm.push_back(8'h03);
      put_fill(3, 8'h00); put16(16'h0800); put_rand(21); put_rand(4);
      send_frame("R8", 1, 0, -1);
      // R7: disabled pass-through
      put_rand(12); put16(16'h0800); put_rand(25); put_rand(4);
      send_frame("R7", 0, 0, -1);
      // R5: carry-heavy payload
      put_rand(12); put16(16'h0800); put_fill(40, 8'hFF); frm.push_back(8'hFE); put_rand(4);
      send_frame("R5", 1, 0, -1);
      // R9: mode 1 on a type-coded frame
      put_rand(12); put16(16'h0806); put_rand(28); put_rand(4);
      send_frame("R9", 1, 1, -1);

      bp_on = 1'b1;
      // R11: type word ends inside FCS
      put_rand(12); put16(16'h0800); put_rand(2);
      send_frame("R11", 1, 0, -1);
      // R11: very short frame
      put_rand(10);
      send_frame("R11", 1, 0, -1);
      // R11: SNAP header cut short
      put_rand(12); put16(16'h0030); put_rand(6); put_rand(4);
      send_frame("R11", 1, 1, -1);
      // R1: smallest frame with one summed byte
      put_rand(12); put16(16'h0800); put_rand(1); put_rand(4);
      send_frame("R1", 1, 0, -1);
      // R10: enable and mode flipped mid-frame
      put_rand(12); put16(16'h0020); put16(16'hAAAA); frm.push_back(8'h03);
      put_fill(3, 8'h00); put16(16'h0800); put_rand(15); put_rand(4);
      send_frame("R10", 1, 1, 5);
      put_rand(12); put16(16'h0800); put_rand(18); put_rand(4);
      send_frame("R10", 0, 0, 3);
      // R2 and R3 again under backpressure
      for (int r = 0; r < 6; r++) begin
         put_rand(12);
         for (int t = 0; t < r % 4; t++) begin put16(16'h8100); put16(16'(r)); end
         put16(16'h0800); put_rand(9 + r); put_rand(4);
         send_frame((r % 4 == 3) ? "R3" : "R2", 1, 0, -1);
      end

      repeat (2000) begin
         @(negedge clk);
         if (exp_data.size() == 0 && exp_len.size() == 0) break;
      end
      repeat (4) @(negedge clk);
      check("R6", exp_len.size() == 0, exp_len.size(), 0, "pending lengths");
      check("R4", exp_data.size() == 0, exp_data.size(), 0, "pending bytes");
      finish_run();
   end

endmodule